// File: doc/BRIEF.md
# Timer Event Flags and Software Event Generation

This block holds the event flags of a general-purpose timer and the word through which software fires those events by itself. Hardware strobes arrive from the rest of the timer: a counter update, a capture and a compare strobe for each channel, a commutation strobe, a trigger strobe and a break strobe. Each strobe sets a sticky flag. Software reads the flag vector and clears individual bits over a 32-bit word-access register bus. Each channel has a direction input that decides which of its two strobes sets its flag. A capture channel also clears its flag when software reads that channel's captured value.

A write-only generation word fires any of the same events from software. Every written 1 produces a single-cycle event pulse and sets the matching flag, and the word always reads back as zero. A break, from a strobe or from software, also clears the output-enable bit. When the matching enable bit is set, a flag that goes from 0 to 1 produces a single-cycle interrupt request pulse. A separate set of enable bits produces a single-cycle DMA request pulse in the same way.

Flag and generation bit layout, which is the same in every vector: bit 0 update, bits 1 to 4 channels 0 to 3, bit 5 commutation, bit 6 trigger, bit 7 break.

Word map:
- 0x00 control: bit 0 is the output enable (read/write).
- 0x0C enables: bits 7:0 enable interrupts and bits 23:16 enable DMA, each in the flag layout.
- 0x10 flags: a 0 written to a bit clears it, and a 1 leaves it unchanged.
- 0x14 generation: write-only.
- 0x34, 0x38, 0x3C, 0x40: captured value of channels 0 to 3.

Top module: `tmr_evt_top`

## Requirements
- R1: While reset is held, all flags, the output enable, all enables, every pulse output and the read data are 0.
- R2: A write to 0x14 drives `gen_o` with the written bits 7:0 for exactly the cycle after the write edge. `gen_o` then returns to 0 unless 0x14 is written again.
- R3: The update strobe `upd_i` or generation bit 0 sets flag bit 0. The flag stays set until software clears it.
- R4: When `ch_in_mode[k]`=1 (input), `cap_i[k]` sets flag bit 1+k and `cmp_i[k]` is ignored. When `ch_in_mode[k]`=0 (output), `cmp_i[k]` sets the flag and `cap_i[k]` is ignored.
- R5: Generation bits 1 to 4 set channel flags 1 to 4 in either mode. Bit 5 sets the commutation flag and bit 6 sets the trigger flag. `com_i` and `trg_i` set the same flags.
- R6: `brk_i` or generation bit 7 sets flag bit 7 and clears the output enable. This happens even when 0x00 is written with a 1 in the same cycle.
- R7: A write to 0x10 clears each flag whose data bit is 0 and leaves the rest unchanged. A set event in the same cycle wins over the clear.
- R8: A read of a channel's value word returns its 16-bit `cv_i` slice, zero-extended. In input mode the read also clears that channel's flag, unless a set arrives in the same cycle. In output mode the read leaves the flag unchanged.
- R9: `irq_o[b]` pulses for one cycle, in the first cycle in which flag b reads 1 after reading 0, if enable bit b of 0x0C was set before that edge. A set on an already-set flag gives no pulse.
- R10: `dma_o[b]` behaves as in R9, gated by bit 16+b of 0x0C.
- R11: Written bits 31:8 of 0x14 have no effect. Reads of 0x14 return 0, and bits 31:8 of the flag word read as 0.
- R12: Accesses with address bits 1:0 not zero, and accesses to unmapped words, write nothing and read 0.
- R13: `bus_rdata` is registered. It holds the addressed word in the cycle after `bus_rd`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the word accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| upd_i | input | 1 | Counter update strobe |
| cap_i | input | 4 | Per-channel capture strobes |
| cmp_i | input | 4 | Per-channel compare strobes |
| com_i | input | 1 | Commutation strobe |
| trg_i | input | 1 | Trigger strobe |
| brk_i | input | 1 | Break strobe |
| ch_in_mode | input | 4 | Channel direction, 1 = input (capture) |
| cv_i | input | 64 | Captured values, channel k in bits 16k+15:16k |
| flag_o | output | 8 | Flag vector |
| poen_o | output | 1 | Output enable |
| gen_o | output | 8 | Software event pulses |
| irq_o | output | 8 | Interrupt request pulses |
| dma_o | output | 8 | DMA request pulses |

## Verification
The hardest cases to reach are the same-cycle collisions: a set arriving in the cycle of a clear, and a clear arriving in the cycle of a set. Each one only shows up if a bus access and a strobe land on the same edge. One case is a capture strobe on the cycle that a value read clears the channel flag. Another is an update strobe under a zero write to the flag word. A third is a break under a write that sets the output enable. The stimulus first builds each collision by hand, holding the strobe and the bus access across a single edge. It then runs thousands of cycles of random strobes, mode changes and bus accesses, including misaligned and unmapped ones. A behavioural model checks every output on every clock.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int DMA_LSB = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENA  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_GEN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CV0  = 8'h34;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_ena;
        logic wr_flag;
        logic wr_gen;
        logic rd_ctrl;
        logic rd_ena;
        logic rd_flag;
    } acc_t;

endpackage

// File: rtl/tmr_evt_decode.sv
module tmr_evt_decode
    import tmr_evt_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_t              acc,
    output logic [NCH-1:0]    rd_cv
);

    logic aligned;
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        acc         = '0;
        acc.wr_ctrl = wr && aligned && (addr == OFS_CTRL);
        acc.wr_ena  = wr && aligned && (addr == OFS_ENA);
        acc.wr_flag = wr && aligned && (addr == OFS_FLAG);
        acc.wr_gen  = wr && aligned && (addr == OFS_GEN);
        acc.rd_ctrl = rd && aligned && (addr == OFS_CTRL);
        acc.rd_ena  = rd && aligned && (addr == OFS_ENA);
        acc.rd_flag = rd && aligned && (addr == OFS_FLAG);
    end

    for (genvar k = 0; k < NCH; k++) begin : g_cv
        localparam logic [ADDR_W-1:0] CV_OFS = OFS_CV0 + ADDR_W'(4 * k);
        assign rd_cv[k] = rd && aligned && (addr == CV_OFS);
    end

endmodule

// File: rtl/tmr_evt_chsel.sv
module tmr_evt_chsel #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] in_mode,
    input  logic [NCH-1:0] cap,
    input  logic [NCH-1:0] cmp,
    output logic [NCH-1:0] hit
);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign hit[k] = in_mode[k] ? cap[k] : cmp[k];
    end

endmodule

// File: rtl/tmr_evt_rdmux.sv
module tmr_evt_rdmux
    import tmr_evt_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CVW = 16
) (
    input  acc_t                acc,
    input  logic [NCH-1:0]      rd_cv,
    input  logic                poen,
    input  logic [NCH+3:0]      ie,
    input  logic [NCH+3:0]      de,
    input  logic [NCH+3:0]      flag,
    input  logic [NCH*CVW-1:0]  cv,
    output logic [DATA_W-1:0]   rd_val
);

    localparam int NFLAG = NCH + 4;

    always_comb begin
        rd_val = '0;
        if (acc.rd_ctrl) begin
            rd_val[0] = poen;
        end
        if (acc.rd_ena) begin
            rd_val[NFLAG-1:0]        = ie;
            rd_val[DMA_LSB +: NFLAG] = de;
        end
        if (acc.rd_flag) begin
            rd_val[NFLAG-1:0] = flag;
        end
        for (int k = 0; k < NCH; k++) begin
            if (rd_cv[k]) begin
                rd_val[CVW-1:0] = cv[k*CVW +: CVW];
            end
        end
    end

endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
    import tmr_evt_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CVW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 upd_i,
    input  logic [NCH-1:0]       cap_i,
    input  logic [NCH-1:0]       cmp_i,
    input  logic                 com_i,
    input  logic                 trg_i,
    input  logic                 brk_i,
    input  logic [NCH-1:0]       ch_in_mode,
    input  logic [NCH*CVW-1:0]   cv_i,
    output logic [NCH+3:0]       flag_o,
    output logic                 poen_o,
    output logic [NCH+3:0]       gen_o,
    output logic [NCH+3:0]       irq_o,
    output logic [NCH+3:0]       dma_o
);

    localparam int NFLAG   = NCH + 4;
    localparam int BIT_BRK = NCH + 3;
    localparam int CH_LSB  = 1;

    typedef struct packed {
        logic              poen;
        logic [NFLAG-1:0]  ie;
        logic [NFLAG-1:0]  de;
        logic [NFLAG-1:0]  flag;
        logic [NFLAG-1:0]  gen;
        logic [NFLAG-1:0]  irq;
        logic [NFLAG-1:0]  dma;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_q, st_d;

    acc_t              acc;
    logic [NCH-1:0]    rd_cv;
    logic [NCH-1:0]    ch_hit;
    logic [DATA_W-1:0] rd_val;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    tmr_evt_decode #(.NCH(NCH)) u_decode (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .acc   (acc),
        .rd_cv (rd_cv)
    );

    tmr_evt_chsel #(.NCH(NCH)) u_chsel (
        .in_mode (ch_in_mode),
        .cap     (cap_i),
        .cmp     (cmp_i),
        .hit     (ch_hit)
    );

    tmr_evt_rdmux #(.NCH(NCH), .CVW(CVW)) u_rdmux (
        .acc    (acc),
        .rd_cv  (rd_cv),
        .poen   (st_q.poen),
        .ie     (st_q.ie),
        .de     (st_q.de),
        .flag   (st_q.flag),
        .cv     (cv_i),
        .rd_val (rd_val)
    );

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] rise_v;
    logic [NFLAG-1:0] gen_v;

    always_comb begin
        st_d = st_q;

        gen_v = acc.wr_gen ? bus_wdata[NFLAG-1:0] : '0;
        set_v = {brk_i, trg_i, com_i, ch_hit, upd_i} | gen_v;

        clr_v = '0;
        if (acc.wr_flag) begin
            clr_v = ~bus_wdata[NFLAG-1:0];
        end
        for (int k = 0; k < NCH; k++) begin
            if (rd_cv[k] && ch_in_mode[k]) begin
                clr_v[CH_LSB + k] = 1'b1;
            end
        end

        rise_v    = set_v & ~st_q.flag;
        st_d.flag = (st_q.flag & ~clr_v) | set_v;
        st_d.irq  = rise_v & st_q.ie;
        st_d.dma  = rise_v & st_q.de;
        st_d.gen  = gen_v;

        if (acc.wr_ctrl) begin
            st_d.poen = bus_wdata[0];
        end
        if (set_v[BIT_BRK]) begin
            st_d.poen = 1'b0;
        end

        if (acc.wr_ena) begin
            st_d.ie = bus_wdata[NFLAG-1:0];
            st_d.de = bus_wdata[DMA_LSB +: NFLAG];
        end

        st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o    = st_q.flag;
    assign poen_o    = st_q.poen;
    assign gen_o     = st_q.gen;
    assign irq_o     = st_q.irq;
    assign dma_o     = st_q.dma;
    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/tmr_evt_chk.sv
module tmr_evt_chk
    import tmr_evt_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [NCH+3:0]    wdata_lo,
    input logic [31:0]       bus_rdata,
    input logic              upd_i,
    input logic              brk_i,
    input logic [NCH+3:0]    flag_o,
    input logic              poen_o,
    input logic [NCH+3:0]    gen_o,
    input logic [NCH+3:0]    irq_o,
    input logic [NCH+3:0]    dma_o
);

    localparam int BIT_BRK = NCH + 3;

    p_gen_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_GEN) |=> (gen_o == $past(wdata_lo)));

    p_gen_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((gen_o != '0) && !(bus_wr && bus_addr == OFS_GEN)) |=> (gen_o == '0));

    p_upd_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> flag_o[0]);

    p_brk_drops_poen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i || (bus_wr && bus_addr == OFS_GEN && wdata_lo[BIT_BRK]))
        |=> (!poen_o && flag_o[BIT_BRK]));

    p_irq_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~flag_o) == '0) && ((irq_o & $past(flag_o)) == '0));

    p_dma_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_o & ~flag_o) == '0) && ((dma_o & $past(flag_o)) == '0));

    p_gen_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_GEN) |=> (bus_rdata == '0));

    p_misaligned_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] != 2'b00 && !brk_i) |=> $stable(poen_o));

    p_idle_rdata_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind tmr_evt_top tmr_evt_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .wdata_lo  (bus_wdata[NCH+3:0]),
    .bus_rdata (bus_rdata),
    .upd_i     (upd_i),
    .brk_i     (brk_i),
    .flag_o    (flag_o),
    .poen_o    (poen_o),
    .gen_o     (gen_o),
    .irq_o     (irq_o),
    .dma_o     (dma_o)
);

// File: tb/tmr_evt_top_tb_top.sv
`timescale 1ns/1ps
module tmr_evt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        upd_i = 1'b0;
    logic [3:0]  cap_i = '0;
    logic [3:0]  cmp_i = '0;
    logic        com_i = 1'b0;
    logic        trg_i = 1'b0;
    logic        brk_i = 1'b0;
    logic [3:0]  ch_in_mode = '0;
    logic [63:0] cv_i = 64'hD004_C003_B002_A001;
    logic [7:0]  flag_o, gen_o, irq_o, dma_o;
    logic        poen_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0]  m_flag = '0, m_gen = '0, m_irq = '0, m_dma = '0, m_ie = '0, m_de = '0;
    logic        m_poen = 1'b0;
    logic [31:0] m_rdata = '0;

    always #2.5 clk = ~clk;

    tmr_evt_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upd_i(upd_i), .cap_i(cap_i),
        .cmp_i(cmp_i), .com_i(com_i), .trg_i(trg_i), .brk_i(brk_i), .ch_in_mode(ch_in_mode),
        .cv_i(cv_i), .flag_o(flag_o), .poen_o(poen_o), .gen_o(gen_o), .irq_o(irq_o), .dma_o(dma_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = '0; m_gen = '0; m_irq = '0; m_dma = '0;
            m_ie = '0; m_de = '0; m_poen = 1'b0; m_rdata = '0;
        end else begin
            logic [7:0]  s, c, nf;
            logic [31:0] rv;
            s = '0; c = '0; rv = '0;
            if (upd_i) s[0] = 1'b1;
            for (int k = 0; k < 4; k++) begin
                if (ch_in_mode[k] ? cap_i[k] : cmp_i[k]) s[k+1] = 1'b1;
            end
            if (com_i) s[5] = 1'b1;
            if (trg_i) s[6] = 1'b1;
            if (brk_i) s[7] = 1'b1;
            if (bus_wr && bus_addr == 8'h14) s = s | bus_wdata[7:0];
            if (bus_wr && bus_addr == 8'h10) c = ~bus_wdata[7:0];
            if (bus_rd) begin
                case (bus_addr)
                    8'h00: rv = {31'd0, m_poen};
                    8'h0C: rv = {8'd0, m_de, 8'd0, m_ie};
                    8'h10: rv = {24'd0, m_flag};
                    8'h34: begin rv = {16'd0, cv_i[15:0]};  if (ch_in_mode[0]) c[1] = 1'b1; end
                    8'h38: begin rv = {16'd0, cv_i[31:16]}; if (ch_in_mode[1]) c[2] = 1'b1; end
                    8'h3C: begin rv = {16'd0, cv_i[47:32]}; if (ch_in_mode[2]) c[3] = 1'b1; end
                    8'h40: begin rv = {16'd0, cv_i[63:48]}; if (ch_in_mode[3]) c[4] = 1'b1; end
                    default: rv = '0;
                endcase
            end
            nf = (m_flag & ~c) | s;
            m_irq = s & ~m_flag & m_ie;
            m_dma = s & ~m_flag & m_de;
            m_flag = nf;
            m_gen = (bus_wr && bus_addr == 8'h14) ? bus_wdata[7:0] : 8'h00;
            if (bus_wr && bus_addr == 8'h00) m_poen = bus_wdata[0];
            if (s[7]) m_poen = 1'b0;
            if (bus_wr && bus_addr == 8'h0C) begin
                m_ie = bus_wdata[7:0];
                m_de = bus_wdata[23:16];
            end
            m_rdata = rv;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        chk("R3 flag vector vs model", {24'd0, flag_o}, {24'd0, m_flag});
        chk("R2 generation pulses vs model", {24'd0, gen_o}, {24'd0, m_gen});
        chk("R6 output enable vs model", {31'd0, poen_o}, {31'd0, m_poen});
        chk("R9 interrupt pulses vs model", {24'd0, irq_o}, {24'd0, m_irq});
        chk("R10 DMA pulses vs model", {24'd0, dma_o}, {24'd0, m_dma});
        chk("R13 read data vs model", bus_rdata, m_rdata);
    endtask

    task automatic step();
        @(negedge clk);
        compare_model();
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        // R1: reset state
        chk("R1 flags in reset", {24'd0, flag_o}, 32'd0);
        chk("R1 poen in reset", {31'd0, poen_o}, 32'd0);
        chk("R1 pulses in reset", {gen_o, irq_o, dma_o}, 32'd0);
        chk("R1 rdata in reset", bus_rdata, 32'd0);
        rst_n = 1'b1;
        step();

        bus_write(8'h00, 32'h1);
        bus_read(8'h00);
        chk("R13 control read one cycle later", bus_rdata, 32'h1);
        bus_write(8'h0C, 32'h000F_00FF);

        upd_i = 1'b1; step(); upd_i = 1'b0;
        chk("R3 update sets flag", {31'd0, flag_o[0]}, 32'd1);
        chk("R9 irq on update", {24'd0, irq_o}, 32'h01);
        chk("R10 dma on update", {24'd0, dma_o}, 32'h01);
        step();
        chk("R9 irq lasts one cycle", {24'd0, irq_o}, 32'h0);

        // set and clear together: set wins, no new pulse
        upd_i = 1'b1; bus_write(8'h10, 32'h0); upd_i = 1'b0;
        chk("R7 set wins over clear", {24'd0, flag_o}, 32'h01);
        chk("R9 no pulse on already-set flag", {24'd0, irq_o}, 32'h0);
        bus_write(8'h10, 32'hFFFF_FFFE);
        chk("R7 zero bit clears", {24'd0, flag_o}, 32'h0);

        ch_in_mode = 4'b0101;
        cmp_i = 4'b0001; step(); cmp_i = '0;
        chk("R4 compare ignored in input mode", {24'd0, flag_o}, 32'h0);
        cap_i = 4'b0001; step(); cap_i = '0;
        chk("R4 capture sets in input mode", {24'd0, flag_o}, 32'h02);
        cmp_i = 4'b0010; step(); cmp_i = '0;
        chk("R4 compare sets in output mode", {24'd0, flag_o}, 32'h06);
        bus_write(8'h10, ~32'h4);
        cap_i = 4'b0010; step(); cap_i = '0;
        chk("R4 capture ignored in output mode", {24'd0, flag_o}, 32'h02);

        cmp_i = 4'b0010; step(); cmp_i = '0;
        bus_read(8'h38);
        chk("R8 value of channel 1", bus_rdata, 32'h0000_B002);
        chk("R8 output-mode read keeps flag", {24'd0, flag_o}, 32'h06);
        bus_read(8'h34);
        chk("R8 value of channel 0", bus_rdata, 32'h0000_A001);
        chk("R8 input-mode read clears flag", {24'd0, flag_o}, 32'h04);
        cap_i = 4'b0001; bus_read(8'h34); cap_i = '0;
        chk("R8 capture wins over read clear", {24'd0, flag_o}, 32'h06);

        bus_write(8'h10, 32'h0);
        bus_write(8'h14, 32'hFFFF_FF40);
        chk("R2 generation pulse", {24'd0, gen_o}, 32'h40);
        chk("R5 trigger generation sets flag", {24'd0, flag_o}, 32'h40);
        chk("R9 irq on generated trigger", {24'd0, irq_o}, 32'h40);
        chk("R10 dma gated off", {24'd0, dma_o}, 32'h0);
        step();
        chk("R2 generation pulse clears", {24'd0, gen_o}, 32'h0);
        bus_read(8'h14);
        chk("R11 generation word reads zero", bus_rdata, 32'h0);
        bus_read(8'h10);
        chk("R11 flag word upper bits zero", bus_rdata, 32'h40);

        bus_write(8'h14, 32'h1E);
        chk("R5 channel generation any mode", {24'd0, flag_o}, 32'h5E);
        bus_write(8'h14, 32'h21);
        chk("R5 commutation and update generation", {24'd0, flag_o}, 32'h7F);

        bus_write(8'h14, 32'h80);
        chk("R6 generated break drops poen", {31'd0, poen_o}, 32'd0);
        chk("R6 generated break sets flag", {24'd0, flag_o}, 32'hFF);
        brk_i = 1'b1; bus_write(8'h00, 32'h1); brk_i = 1'b0;
        chk("R6 break wins over poen write", {31'd0, poen_o}, 32'd0);
        bus_write(8'h00, 32'h1);
        chk("R6 poen set again", {31'd0, poen_o}, 32'd1);

        bus_write(8'h01, 32'h0);
        chk("R12 misaligned write ignored", {31'd0, poen_o}, 32'd1);
        bus_read(8'h0E);
        chk("R12 misaligned read zero", bus_rdata, 32'h0);
        bus_read(8'h50);
        chk("R12 unmapped read zero", bus_rdata, 32'h0);

        bus_write(8'h10, 32'h0);
        bus_write(8'h14, 32'hFFFF_FF00);
        chk("R11 reserved generation bits ignored", {gen_o, flag_o}, 32'h0);

        // random phase, model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] alist [10];
            int r;
            alist = '{8'h00, 8'h0C, 8'h10, 8'h14, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h01, 8'h50};
            if (n % 64 == 0) ch_in_mode = 4'($urandom);
            upd_i = ($urandom % 8) == 0;
            cap_i = 4'($urandom) & 4'($urandom);
            cmp_i = 4'($urandom) & 4'($urandom);
            com_i = ($urandom % 16) == 0;
            trg_i = ($urandom % 16) == 0;
            brk_i = ($urandom % 32) == 0;
            r = $urandom % 10;
            bus_addr = alist[$urandom % 10];
            bus_wdata = $urandom;
            bus_wr = (r < 3);
            bus_rd = (r >= 3) && (r < 7);
            if (bus_wr && bus_addr == 8'h10) bus_wdata[7:0] = bus_wdata[7:0] | 8'($urandom);
            step();
        end
        upd_i = 1'b0; cap_i = '0; cmp_i = '0; com_i = 1'b0; trg_i = 1'b0; brk_i = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0;
        step();

        done = 1;
        summary();
        $finish;
    end

endmodule